// File: doc/BRIEF.md
# Time-Matched Trigger Bank

This block holds a bank of independently programmed triggers that turn a free-running nanosecond time value into output waveforms. Each trigger keeps an activation time, a width and a period. When the incoming time reaches the activation time, the trigger makes one of four waveforms:

- a single rising edge,
- a single falling edge,
- one pulse,
- a repeating pulse train.

The repeating train is how a once-per-second marker is produced: set the period to 1,000,000,000 ns.

Each trigger is steered to one of several output lines. All triggers that share a line are ORed together, so a few triggers on one line can build a sequence of pulses of different widths.

Software sets up the bank through a single-cycle write port. Each write names a trigger, a field and a 64-bit value. The time value comes from the chip's time-keeping logic, already in this clock domain.

Top module: `trig_bank`

## Requirements
- R1: After reset every output line is low and every trigger is disarmed.
- R2: A control write (field 0) loads the mode from bits [1:0], where 0 = rise, 1 = fall, 2 = pulse and 3 = periodic. It loads the line select from bits starting at bit 4. If bit 2 (arm) is set, the activation time is latched from the start field (field 1). From the next cycle the trigger's output is at its idle level: high in fall mode, low in every other mode.
- R3: An armed trigger fires at the clock edge where the time input is greater than or equal to its activation time. A time jump past the activation time still fires it. Before that edge the output does not change.
- R4: In rise mode, firing drives the output high. It stays high and the trigger disarms.
- R5: In fall mode, firing drives the output low. It stays low and the trigger disarms.
- R6: In pulse mode, firing drives the output high. The output goes low at the first edge where time is at or beyond activation time plus the width field (field 2). This happens only once.
- R7: In periodic mode, each firing drives the output high and advances the activation time by the period field (field 3). The output goes low once time reaches the previous activation time plus the width, and the cycle repeats.
- R8: Bit 3 (disarm) of a control write drives the output low at the next edge and stops all further activity. It wins over an arm bit in the same write.
- R9: Each line is the OR of the outputs of the triggers whose line select names it. Other lines are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_ns | input | 64 | Current time in nanoseconds |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 3 | Trigger index for the write |
| wr_addr | input | 2 | Field: 0 control, 1 start, 2 width, 3 period |
| wr_data | input | 64 | Write value |
| trig_lines | output | 4 | Combined trigger output lines |

## Verification
The bench jumps the time input over an activation time. A design that used equality instead of greater-or-equal would never fire there.

It puts two pulses of different widths on one line and checks the gap between them. A design that routed or ORed wrongly would merge the pulses, drop one, or leak onto another line.

It sets arm and disarm in the same write. A design with the wrong priority would fire at once.

Random periodic triggers are compared every cycle against a closed-form model of high time and period. An error in how the next activation is advanced shows up as drift or as a missing edge.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    TM_RISE   = 2'd0,
    TM_FALL   = 2'd1,
    TM_PULSE  = 2'd2,
    TM_PERIOD = 2'd3
  } trig_mode_e;

  localparam logic [1:0] FLD_CTRL   = 2'd0;
  localparam logic [1:0] FLD_START  = 2'd1;
  localparam logic [1:0] FLD_WIDTH  = 2'd2;
  localparam logic [1:0] FLD_PERIOD = 2'd3;

  localparam int CB_ARM  = 2;
  localparam int CB_DIS  = 3;
  localparam int CB_LINE = 4;
endpackage

// File: rtl/trig_slot.sv
module trig_slot
  import trig_pkg::*;
#(
  parameter int TW = 64,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_i,
  input  logic          hit_i,
  input  logic [1:0]    addr_i,
  input  logic [TW-1:0] data_i,
  output logic          out_o,
  output logic [LW-1:0] line_o
);
  trig_mode_e    mode_q, mode_n;
  logic [LW-1:0] line_q, line_n;
  logic [TW-1:0] start_q, start_n, width_q, width_n, period_q, period_n;
  logic [TW-1:0] act_q, act_n, end_q, end_n;
  logic          armed_q, armed_n, hi_q, hi_n, out_q, out_n;
  logic          is_ctrl, arm, dis, reach_act, reach_end;

  always_comb begin
    mode_n   = mode_q;
    line_n   = line_q;
    start_n  = start_q;
    width_n  = width_q;
    period_n = period_q;
    act_n    = act_q;
    end_n    = end_q;
    armed_n  = armed_q;
    hi_n     = hi_q;
    out_n    = out_q;

    is_ctrl   = hit_i && (addr_i == FLD_CTRL);
    arm       = is_ctrl && data_i[CB_ARM];
    dis       = is_ctrl && data_i[CB_DIS];
    reach_act = (time_i >= act_q);
    reach_end = (time_i >= end_q);

    if (is_ctrl) begin
      mode_n = trig_mode_e'(data_i[1:0]);
      line_n = data_i[CB_LINE +: LW];
    end
    if (hit_i && addr_i == FLD_START)  start_n  = data_i;
    if (hit_i && addr_i == FLD_WIDTH)  width_n  = data_i;
    if (hit_i && addr_i == FLD_PERIOD) period_n = data_i;

    if (dis) begin
      armed_n = 1'b0;
      hi_n    = 1'b0;
      out_n   = 1'b0;
    end else if (arm) begin
      armed_n = 1'b1;
      hi_n    = 1'b0;
      act_n   = start_q;
      out_n   = (mode_n == TM_FALL);
    end else if (armed_q) begin
      unique case (mode_q)
        TM_RISE: if (reach_act) begin
          out_n   = 1'b1;
          armed_n = 1'b0;
        end
        TM_FALL: if (reach_act) begin
          out_n   = 1'b0;
          armed_n = 1'b0;
        end
        TM_PULSE: begin
          if (!hi_q && reach_act) begin
            out_n = 1'b1;
            hi_n  = 1'b1;
            end_n = act_q + width_q;
          end else if (hi_q && reach_end) begin
            out_n   = 1'b0;
            hi_n    = 1'b0;
            armed_n = 1'b0;
          end
        end
        TM_PERIOD: begin
          if (!hi_q && reach_act) begin
            out_n = 1'b1;
            hi_n  = 1'b1;
            end_n = act_q + width_q;
            act_n = act_q + period_q;
          end else if (hi_q && reach_end) begin
            out_n = 1'b0;
            hi_n  = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= TM_RISE;
      line_q   <= '0;
      start_q  <= '0;
      width_q  <= '0;
      period_q <= '0;
      act_q    <= '0;
      end_q    <= '0;
      armed_q  <= 1'b0;
      hi_q     <= 1'b0;
      out_q    <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      line_q   <= line_n;
      start_q  <= start_n;
      width_q  <= width_n;
      period_q <= period_n;
      act_q    <= act_n;
      end_q    <= end_n;
      armed_q  <= armed_n;
      hi_q     <= hi_n;
      out_q    <= out_n;
    end
  end

  assign out_o  = out_q;
  assign line_o = line_q;

  p_arm_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !dis) |=> (armed_q && (out_q == (mode_q == TM_FALL))));
  p_no_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !hi_q && !reach_act && !is_ctrl) |=> $stable(out_q));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !is_ctrl) |=> $stable(out_q));
  p_high_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q |-> out_q);
  p_disarm_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> (!out_q && !armed_q));
endmodule

// File: rtl/trig_route.sv
module trig_route #(
  parameter int N_TRIG  = 8,
  parameter int N_LINES = 4,
  parameter int LW      = 2
) (
  input  logic [N_TRIG-1:0]         outs_i,
  input  logic [N_TRIG-1:0][LW-1:0] sel_i,
  output logic [N_LINES-1:0]        lines_o
);
  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    always_comb begin
      lines_o[l] = 1'b0;
      for (int i = 0; i < N_TRIG; i++) begin
        if (outs_i[i] && (sel_i[i] == LW'(l))) lines_o[l] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_bank.sv
module trig_bank #(
  parameter int N_TRIG  = 8,
  parameter int N_LINES = 4,
  parameter int TW      = 64,
  localparam int IW = (N_TRIG  > 1) ? $clog2(N_TRIG)  : 1,
  localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TW-1:0]      time_ns,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [1:0]         wr_addr,
  input  logic [TW-1:0]      wr_data,
  output logic [N_LINES-1:0] trig_lines
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [N_TRIG-1:0]         slot_out;
  logic [N_TRIG-1:0][LW-1:0] slot_line;

  for (genvar i = 0; i < N_TRIG; i++) begin : g_slot
    trig_slot #(.TW(TW), .LW(LW)) u_slot (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .time_i (time_ns),
      .hit_i  (wr_en && (wr_idx == IW'(i))),
      .addr_i (wr_addr),
      .data_i (wr_data),
      .out_o  (slot_out[i]),
      .line_o (slot_line[i])
    );
  end

  trig_route #(.N_TRIG(N_TRIG), .N_LINES(N_LINES), .LW(LW)) u_route (
    .outs_i  (slot_out),
    .sel_i   (slot_line),
    .lines_o (trig_lines)
  );

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_core_n |=> (slot_out == '0));
endmodule

// File: tb/trig_bank_test.sv
module trig_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int NL = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] time_ns;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_addr;
  logic [63:0] wr_data;
  logic [3:0]  trig_lines;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic        m_on   [NT];
  int          m_line [NT];
  logic [63:0] m_start[NT], m_w[NT], m_p[NT];

  trig_bank uut (
    .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_lines(trig_lines)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] ctrl(int mode, bit arm, bit dis, int line);
    return 64'(mode) | (64'(arm) << 2) | (64'(dis) << 3) | (64'(line) << 4);
  endfunction

  function automatic logic [3:0] model_lines(logic [63:0] t);
    logic [3:0] r = '0;
    for (int i = 0; i < NT; i++)
      if (m_on[i] && t >= m_start[i] && ((t - m_start[i]) % m_p[i]) < m_w[i])
        r[m_line[i]] = 1'b1;
    return r;
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: lines actual %b expected %b at t=%0d", req, act, exp, time_ns);
    end
  endtask

  task automatic tick(logic [63:0] t);
    @(negedge clk);
    time_ns = t;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(int idx, int addr, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_addr = 2'(addr); wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NT; i++) m_on[i] = 1'b0;
    rst_n = 1'b0; time_ns = '0; wr_en = 0; wr_idx = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset", trig_lines, 4'b0000);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R1 after release", trig_lines, 4'b0000);

    // R4 rise on line 0, R3 jump past activation
    wr(0, 1, 64'd100);
    wr(0, 0, ctrl(0, 1, 0, 0));
    chk("R2 rise idle low", trig_lines, 4'b0000);
    tick(96);  chk("R3 before match", trig_lines, 4'b0000);
    tick(104); chk("R3 jump past start fires", trig_lines, 4'b0001);
    tick(200); chk("R4 rise holds high", trig_lines, 4'b0001);

    // R5 fall on line 1
    wr(1, 1, 64'd300);
    wr(1, 0, ctrl(1, 1, 0, 1));
    chk("R2 fall idle high", trig_lines, 4'b0011);
    tick(296); chk("R5 before match", trig_lines, 4'b0011);
    tick(300); chk("R5 fall at match", trig_lines, 4'b0001);
    tick(400); chk("R5 stays low", trig_lines, 4'b0001);

    // R6 pulse on line 2
    wr(2, 1, 64'd500);
    wr(2, 2, 64'd40);
    wr(2, 0, ctrl(2, 1, 0, 2));
    tick(496); chk("R6 before pulse", trig_lines, 4'b0001);
    tick(500); chk("R6 pulse high", trig_lines, 4'b0101);
    tick(536); chk("R6 pulse still high", trig_lines, 4'b0101);
    tick(540); chk("R6 pulse low at end", trig_lines, 4'b0001);
    tick(600); chk("R6 single pulse", trig_lines, 4'b0001);

    // R8 disarm and priority over arm
    wr(0, 0, ctrl(0, 0, 1, 0));
    chk("R8 disarm drops line", trig_lines, 4'b0000);
    tick(1000);
    wr(3, 1, 64'd0);
    wr(3, 0, ctrl(0, 1, 1, 3));
    chk("R8 disarm wins over arm", trig_lines, 4'b0000);
    tick(1008); chk("R8 no late fire", trig_lines, 4'b0000);

    // R9 two pulses ORed on line 3
    tick(1050);
    wr(4, 1, 64'd1100); wr(4, 2, 64'd20); wr(4, 0, ctrl(2, 1, 0, 3));
    wr(5, 1, 64'd1140); wr(5, 2, 64'd40); wr(5, 0, ctrl(2, 1, 0, 3));
    tick(1092); chk("R9 quiet", trig_lines, 4'b0000);
    tick(1100); chk("R9 first pulse", trig_lines, 4'b1000);
    tick(1110); chk("R9 first pulse", trig_lines, 4'b1000);
    tick(1120); chk("R9 gap", trig_lines, 4'b0000);
    tick(1130); chk("R9 gap", trig_lines, 4'b0000);
    tick(1140); chk("R9 second pulse", trig_lines, 4'b1000);
    tick(1170); chk("R9 second pulse wide", trig_lines, 4'b1000);
    tick(1180); chk("R9 end", trig_lines, 4'b0000);

    // R7 directed periodic on line 1
    wr(6, 1, 64'd2000); wr(6, 2, 64'd16); wr(6, 3, 64'd40);
    wr(6, 0, ctrl(3, 1, 0, 1));
    tick(1992); chk("R7 before", trig_lines, 4'b0000);
    tick(2000); chk("R7 first high", trig_lines, 4'b0010);
    tick(2008); chk("R7 high", trig_lines, 4'b0010);
    tick(2016); chk("R7 low at width", trig_lines, 4'b0000);
    tick(2032); chk("R7 low", trig_lines, 4'b0000);
    tick(2040); chk("R7 second period", trig_lines, 4'b0010);
    tick(2056); chk("R7 low again", trig_lines, 4'b0000);
    tick(2080); chk("R7 third period", trig_lines, 4'b0010);

    // random periodic phase: R7 and R9 against closed-form model
    for (int i = 0; i < NT; i++) wr(i, 0, ctrl(0, 0, 1, 0));
    chk("R8 all disarmed", trig_lines, 4'b0000);
    tick(5000);
    for (int i = 0; i < NT; i++) begin
      m_on[i]    = ($urandom % 4) != 0;
      m_line[i]  = $urandom % NL;
      m_w[i]     = 64'(8 * (1 + $urandom % 6));
      m_p[i]     = m_w[i] + 64'(8 * (1 + $urandom % 12));
      m_start[i] = 64'(5000 + 8 * (1 + $urandom % 20));
      if (m_on[i]) begin
        wr(i, 1, m_start[i]); wr(i, 2, m_w[i]); wr(i, 3, m_p[i]);
        wr(i, 0, ctrl(3, 1, 0, m_line[i]));
      end
    end
    for (int c = 1; c <= 600; c++) begin
      logic [63:0] t = 64'(5000 + 8 * c);
      tick(t);
      chk("R7/R9 random periodic", trig_lines, model_lines(t));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule